// File: doc/BRIEF.md
# Aperiodic Transfer Descriptor Scheduler

This block keeps a table of bulk and control transfer descriptors for a host controller and decides which one goes out on the bus next. Software fills descriptor slots through a register write port. Each slot holds a token direction, a device address, a speed flag, a byte count and two pairing flags. A frame-start strobe opens a scheduling window. Inside that window the block issues eligible descriptors one at a time. After each issue it waits for the transaction-complete handshake before it picks the next one. The window closes when nothing is left to issue.

Two neighbouring slots can serve one endpoint as a double buffer. The even slot is the first half and the odd slot is the second half. The second half is held back until the first half of the same pair has completed. Because the search restarts just after the slot last issued, the two halves alternate back to back. A host-written skip mask keeps slots out of the search. A done bitmap records completions. An interrupt rises once a programmed number of completions has accumulated, and a done-map read strobe clears the map, the completion count and the interrupt.

Top module: `atd_sched`

## Requirements
- R1: After reset, `iss_valid`, `irq` and every bit of `done_map` are 0.
- R2: A descriptor is issued only while a window opened by `frame_start` is open. A window closes on the first cycle in which nothing is eligible and nothing is in flight. A slot made eligible after that waits for the next `frame_start`.
- R3: Eligible slots are searched in round-robin order. The search starts at the index one past the last issued slot and wraps from ENTRIES-1 to 0. After reset, the search starts at slot 0.
- R4: A slot whose bit is set in the skip mask is never issued while that bit is set.
- R5: A slot whose direction code is 2'b11 (reserved) is never issued. The direction codes are 00 setup, 01 OUT and 10 IN.
- R6: Paired slots form pairs 2k/2k+1. The even slot must have buffer bit 0 and the odd slot must have buffer bit 1; a paired slot with the wrong parity is never issued. An odd (second) half is issued only after its even partner has completed, and that permission is withdrawn when the odd half completes or either slot is rewritten. `bus_pong` is 1 while the issued descriptor is a paired second half.
- R7: When `xfer_ack` is high while `iss_valid` is high, the issued slot's `done_map` bit is set and `iss_valid` drops on the next cycle. A slot whose done bit is set is not issued again until that bit is cleared, either by a read clear or by a rewrite of the slot.
- R8: `irq` rises once the count of completions since the last read clear reaches a nonzero threshold. It then stays high until `rd_done`. A threshold of 0 never raises `irq`.
- R9: A `rd_done` pulse clears `done_map`, the completion count and `irq` on the next cycle.
- R10: Write port encoding. When `wr_addr[4]` is 0, `wr_addr[3:0]` selects a slot, and the data fields are: bits 1:0 direction, bits 8:2 address, bit 9 low-speed, bits 19:10 byte count, bit 20 paired, bit 21 buffer, bit 22 active. Address 16 loads the skip mask from data bits 15:0. Address 17 loads the threshold from data bits 5:0. The issued slot's fields appear on the `iss_*` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Slot index or control register select |
| wr_data | input | 32 | Write data |
| frame_start | input | 1 | Opens a scheduling window |
| xfer_ack | input | 1 | Transaction-complete handshake for the issued slot |
| rd_done | input | 1 | Done-map read strobe (clears map, count, irq) |
| iss_valid | output | 1 | A descriptor is issued and awaiting completion |
| iss_idx | output | 4 | Issued slot index |
| iss_dir | output | 2 | Issued direction code |
| iss_faddr | output | 7 | Issued device address |
| iss_low | output | 1 | Issued speed flag (1 = low-speed) |
| iss_bytes | output | 10 | Issued total byte count |
| iss_paired | output | 1 | Issued slot is part of a pair |
| bus_pong | output | 1 | Issued slot is the second half of a pair |
| done_map | output | 16 | Completion bitmap |
| irq | output | 1 | Completion-count interrupt |

## Verification
The bench tries the scheduler with several table layouts. A sparse set of slots after reset shows that issue starts at slot 0 in ascending order. A set that straddles the last issued index shows the wrap of the round-robin pointer. A skipped slot next to an unskipped one, and a reserved-direction slot next to a valid one, each show that only the excluded slot is held back. A second half written before its first half shows that the gate holds, and writing the first half later shows the back-to-back alternation. A slot made eligible after its window closed shows that a fresh frame-start is needed, and the interrupt is watched below, at and after the threshold, and with a threshold of zero.

// File: rtl/atd_sched.sv
module atd_sched #(
  parameter int ENTRIES = 16,
  parameter int BYTEW   = 10,
  parameter int FAW     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(ENTRIES):0]    wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic                        frame_start,
  input  logic                        xfer_ack,
  input  logic                        rd_done,
  output logic                        iss_valid,
  output logic [$clog2(ENTRIES)-1:0]  iss_idx,
  output logic [1:0]                  iss_dir,
  output logic [FAW-1:0]              iss_faddr,
  output logic                        iss_low,
  output logic [BYTEW-1:0]            iss_bytes,
  output logic                        iss_paired,
  output logic                        bus_pong,
  output logic [ENTRIES-1:0]          done_map,
  output logic                        irq
);
  localparam int IDXW  = $clog2(ENTRIES);
  localparam int PAIRS = ENTRIES / 2;
  localparam int CNTW  = IDXW + 2;
  localparam int LOWB  = 2 + FAW;
  localparam int BYTB  = LOWB + 1;
  localparam int PRB   = BYTB + BYTEW;

  logic [1:0]       t_dir   [ENTRIES];
  logic [FAW-1:0]   t_fa    [ENTRIES];
  logic [BYTEW-1:0] t_bytes [ENTRIES];
  logic [ENTRIES-1:0] t_low, t_paired, t_pong, t_act;

  logic [ENTRIES-1:0] skip_q, done_q, done_nx, elig;
  logic [PAIRS-1:0]   ps_q, ps_nx;
  logic [CNTW-1:0]    thr_q, cnt_q, cnt_nx;
  logic               irq_nx, open_q, sel_found;
  logic [IDXW-1:0]    last_q, sel_idx, wa;

  wire tbl_wr   = wr_en && !wr_addr[IDXW];
  wire ctl_wr   = wr_en &&  wr_addr[IDXW];
  wire done_now = iss_valid && xfer_ack;
  assign wa       = wr_addr[IDXW-1:0];
  assign done_map = done_q;

  always_ff @(posedge clk) begin
    if (tbl_wr) begin
      t_dir[wa]   <= wr_data[1:0];
      t_fa[wa]    <= wr_data[2 +: FAW];
      t_bytes[wa] <= wr_data[BYTB +: BYTEW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_act <= '0; t_low <= '0; t_paired <= '0; t_pong <= '0;
      skip_q <= '0; thr_q <= '0;
    end else begin
      if (tbl_wr) begin
        t_low[wa]    <= wr_data[LOWB];
        t_paired[wa] <= wr_data[PRB];
        t_pong[wa]   <= wr_data[PRB+1];
        t_act[wa]    <= wr_data[PRB+2];
      end
      if (ctl_wr && wa == IDXW'(0)) skip_q <= wr_data[ENTRIES-1:0];
      if (ctl_wr && wa == IDXW'(1)) thr_q  <= wr_data[CNTW-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic pair_ok;
      if (i % 2 == 0) pair_ok = !t_pong[i];
      else            pair_ok = t_pong[i] && ps_q[i/2];
      elig[i] = t_act[i] && !skip_q[i] && !done_q[i] && (t_dir[i] != 2'b11) &&
                (!t_paired[i] || pair_ok);
    end
  end

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int k = 1; k <= ENTRIES; k++) begin
      int cand;
      cand = (int'(last_q) + k) % ENTRIES;
      if (!sel_found && elig[cand]) begin
        sel_found = 1'b1;
        sel_idx   = IDXW'(cand);
      end
    end
  end

  always_comb begin
    done_nx = rd_done ? '0 : done_q;
    if (tbl_wr)   done_nx[wa] = 1'b0;
    if (done_now) done_nx[iss_idx] = 1'b1;
    ps_nx = ps_q;
    if (tbl_wr) ps_nx[wa[IDXW-1:1]] = 1'b0;
    if (done_now && iss_paired) ps_nx[iss_idx[IDXW-1:1]] = !bus_pong;
    cnt_nx = rd_done ? '0 : cnt_q;
    if (done_now && cnt_nx != '1) cnt_nx = cnt_nx + 1'b1;
    irq_nx = (rd_done ? 1'b0 : irq) || (thr_q != '0 && cnt_nx >= thr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0; iss_valid <= 1'b0; iss_idx <= '0;
      last_q <= IDXW'(ENTRIES - 1);
      iss_dir <= '0; iss_faddr <= '0; iss_low <= 1'b0; iss_bytes <= '0;
      iss_paired <= 1'b0; bus_pong <= 1'b0;
      done_q <= '0; ps_q <= '0; cnt_q <= '0; irq <= 1'b0;
    end else begin
      done_q <= done_nx;
      ps_q   <= ps_nx;
      cnt_q  <= cnt_nx;
      irq    <= irq_nx;
      if (frame_start) open_q <= 1'b1;
      else if (open_q && !iss_valid && !sel_found) open_q <= 1'b0;
      if (done_now) begin
        iss_valid <= 1'b0;
      end else if (!iss_valid && open_q && sel_found) begin
        iss_valid  <= 1'b1;
        iss_idx    <= sel_idx;
        last_q     <= sel_idx;
        iss_dir    <= t_dir[sel_idx];
        iss_faddr  <= t_fa[sel_idx];
        iss_low    <= t_low[sel_idx];
        iss_bytes  <= t_bytes[sel_idx];
        iss_paired <= t_paired[sel_idx];
        bus_pong   <= t_paired[sel_idx] && t_pong[sel_idx];
      end
    end
  end

  // R2
  issue_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iss_valid) |-> $past(open_q));
  // R5
  no_reserved_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_dir != 2'b11);
  // R6
  pong_after_ping_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && bus_pong) |-> ps_q[iss_idx[IDXW-1:1]]);
  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_now && !tbl_wr) |=> (done_map[$past(iss_idx)] && !iss_valid));
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_done) |=> irq);
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !done_now) |=> (done_map == '0 && !irq));
endmodule

// File: tb/atd_sched_tb.sv
`timescale 1ns/1ps
module atd_sched_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, frame_start = 1'b0, xfer_ack = 1'b0, rd_done = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        iss_valid, iss_low, iss_paired, bus_pong, irq;
  logic [3:0]  iss_idx;
  logic [1:0]  iss_dir;
  logic [6:0]  iss_faddr;
  logic [9:0]  iss_bytes;
  logic [15:0] done_map;

  int checks = 0, fails = 0, cycles = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  atd_sched dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .xfer_ack(xfer_ack), .rd_done(rd_done),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_dir(iss_dir), .iss_faddr(iss_faddr),
    .iss_low(iss_low), .iss_bytes(iss_bytes), .iss_paired(iss_paired),
    .bus_pong(bus_pong), .done_map(done_map), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  // monitor: compares each issue against the scoreboard and acknowledges it
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_ack) xfer_ack = 1'b0;
      else if (rst_n && iss_valid) begin
        logic [24:0] act;
        act = {bus_pong, iss_bytes, iss_low, iss_faddr, iss_dir, iss_idx};
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL unexpected issue actual=%0h expected=none", act);
        end else begin
          logic [24:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {7'b0, act}, {7'b0, e});
        end
        xfer_ack = 1'b1;
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic desc(int idx, logic [1:0] dir, logic [6:0] fa, logic low,
                      logic [9:0] nb, logic pr, logic pg, logic act);
    wr(5'(idx), {9'b0, act, pg, pr, nb, low, fa, dir});
  endtask

  task automatic expect_iss(string t, int idx, logic [1:0] dir, logic [6:0] fa,
                            logic low, logic [9:0] nb, logic pg);
    exp_q.push_back({pg, nb, low, fa, dir, 4'(idx)});
    tag_q.push_back(t);
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL drain pending actual=%0d expected=0", exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) desc(i, 2'b00, 7'd0, 1'b0, 10'd0, 1'b0, 1'b0, 1'b0);
    pulse_read();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 iss_valid", 32'(iss_valid), 0);
    chk("R1 done_map", 32'(done_map), 0);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;

    // R10 threshold register, R3 order from slot 0
    wr(5'd17, 32'd3);
    desc(0, 2'b00, 7'd5,  1'b0, 10'd8,   1'b0, 1'b0, 1'b1);
    desc(3, 2'b01, 7'd9,  1'b0, 10'd700, 1'b0, 1'b0, 1'b1);
    desc(5, 2'b10, 7'd33, 1'b1, 10'd64,  1'b0, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    chk("R2 no issue before frame", 32'(iss_valid), 0);
    expect_iss("R3 first", 0, 2'b00, 7'd5, 1'b0, 10'd8, 1'b0);
    expect_iss("R10 fields", 3, 2'b01, 7'd9, 1'b0, 10'd700, 1'b0);
    expect_iss("R3 third", 5, 2'b10, 7'd33, 1'b1, 10'd64, 1'b0);
    pulse_frame();
    drain();
    chk("R7 done map", 32'(done_map), 32'h0029);
    chk("R8 irq at threshold", 32'(irq), 1);
    pulse_frame();
    drain();
    chk("R8 irq holds", 32'(irq), 1);
    pulse_read();
    chk("R9 map cleared", 32'(done_map), 0);
    chk("R9 irq cleared", 32'(irq), 0);
    clear_all();

    // R3 wrap past last issued index (5)
    desc(2, 2'b01, 7'd2, 1'b0, 10'd1, 1'b0, 1'b0, 1'b1);
    desc(7, 2'b10, 7'd7, 1'b0, 10'd2, 1'b0, 1'b0, 1'b1);
    expect_iss("R3 after last", 7, 2'b10, 7'd7, 1'b0, 10'd2, 1'b0);
    expect_iss("R3 wrap", 2, 2'b01, 7'd2, 1'b0, 10'd1, 1'b0);
    pulse_frame();
    drain();
    chk("R8 below threshold", 32'(irq), 0);
    clear_all();

    // R4 skip mask
    wr(5'd16, 32'h0100);
    desc(8, 2'b01, 7'd8, 1'b0, 10'd3, 1'b0, 1'b0, 1'b1);
    desc(9, 2'b01, 7'd9, 1'b0, 10'd4, 1'b0, 1'b0, 1'b1);
    expect_iss("R4 unskipped", 9, 2'b01, 7'd9, 1'b0, 10'd4, 1'b0);
    pulse_frame();
    drain();
    chk("R4 skipped not done", 32'(done_map[8]), 0);
    wr(5'd16, 32'h0);
    expect_iss("R4 after unskip", 8, 2'b01, 7'd8, 1'b0, 10'd3, 1'b0);
    pulse_frame();
    drain();

    // R5 reserved token
    desc(10, 2'b11, 7'd10, 1'b0, 10'd5, 1'b0, 1'b0, 1'b1);
    desc(11, 2'b00, 7'd11, 1'b0, 10'd6, 1'b0, 1'b0, 1'b1);
    expect_iss("R5 valid neighbour", 11, 2'b00, 7'd11, 1'b0, 10'd6, 1'b0);
    pulse_frame();
    drain();
    chk("R5 reserved never done", 32'(done_map[10]), 0);

    // R2 window closed: late slot waits for next frame
    desc(1, 2'b10, 7'd1, 1'b0, 10'd9, 1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk("R2 closed window", 32'(iss_valid), 0);
    chk("R2 late slot idle", 32'(done_map[1]), 0);
    expect_iss("R2 next frame", 1, 2'b10, 7'd1, 1'b0, 10'd9, 1'b0);
    pulse_frame();
    drain();
    clear_all();

    // R6 pairs: second half gated on first half
    desc(13, 2'b01, 7'd20, 1'b0, 10'd64, 1'b1, 1'b1, 1'b1);
    desc(6,  2'b01, 7'd21, 1'b0, 10'd64, 1'b1, 1'b1, 1'b1);
    pulse_frame();
    drain();
    chk("R6 pong held", 32'(done_map[13]), 0);
    chk("R6 wrong parity", 32'(done_map[6]), 0);
    desc(12, 2'b01, 7'd20, 1'b0, 10'd64, 1'b1, 1'b0, 1'b1);
    expect_iss("R6 ping first", 12, 2'b01, 7'd20, 1'b0, 10'd64, 1'b0);
    expect_iss("R6 pong next", 13, 2'b01, 7'd20, 1'b0, 10'd64, 1'b1);
    pulse_frame();
    drain();
    chk("R6 wrong parity still idle", 32'(done_map[6]), 0);
    clear_all();

    // R8 threshold zero disables irq
    wr(5'd17, 32'd0);
    desc(4, 2'b00, 7'd4, 1'b0, 10'd1, 1'b0, 1'b0, 1'b1);
    expect_iss("R8 zero threshold issue", 4, 2'b00, 7'd4, 1'b0, 10'd1, 1'b0);
    pulse_frame();
    drain();
    chk("R8 zero threshold", 32'(irq), 0);

    finish_run();
  end
endmodule